// File: doc/BRIEF.md
# Chunked Millisecond Delay Timer

This block produces a delay of a requested number of milliseconds. A pulse on `start` captures a 16-bit millisecond count. The block then runs a 24-bit down-counter through a series of segments and raises `done` for one cycle when the whole span has elapsed. The counter holds a tick count at the clock rate, which is 120,000 ticks per millisecond by default. A 24-bit reload cannot represent more than about 139 ms at that rate, so the block never loads more than 50 ms worth of ticks at once.

Each segment follows the same steps:

1. Work out the segment length from the milliseconds still owed.
2. Load the counter with that many milliseconds times the tick rate.
3. Count down until the counter reports expiry.
4. Clear the counter and its expiry flag.
5. Start another segment if any milliseconds remain.

Every segment except the last is exactly 50 ms. The last segment carries whatever remains, from 1 ms up to 50 ms.

A controller uses the block wherever a fixed wait is needed between steps of a bring-up sequence. It pulses `start` with a count and proceeds on `done`. The tick rate is a parameter, so a bench can shrink it.

Top module: `ms_delay_chunker`

## Requirements
- R1: A loaded segment of m milliseconds places exactly m × TICKS_PER_MS ticks in the 24-bit counter (TICKS_PER_MS defaults to 120,000).
- R2: When the milliseconds still owed are 50 or fewer, the segment loads all of them and nothing remains owed afterwards.
- R3: When more than 50 ms are owed, the segment loads exactly 50 ms and the amount owed drops by 50.
- R4: Each segment occupies three cycles beyond its tick count: one load cycle, one cycle to notice expiry, and one clear cycle. The clear cycle returns the counter and its expiry flag to zero.
- R5: For a request of n > 0 ms, `done` is first seen high 1 + n × TICKS_PER_MS + 3 × ceil(n / 50) rising edges after the edge that samples `start`.
- R6: A request of 0 ms loads no segment, and `done` is high after the first rising edge following `start`.
- R7: `done` is high for exactly one cycle per accepted request, and only once nothing remains owed.
- R8: `start` and `delay_ms` are ignored while a delay is running. Only the count sampled with the accepting `start` sets the length, and no extra `done` results.
- R9: After reset, `done` is low and the block is idle. Asserting reset during a delay abandons that delay without a `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 120 MHz by default |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request strobe, accepted only while idle |
| delay_ms | input | 16 | Requested delay in milliseconds, sampled with an accepted `start` |
| done | output | 1 | One-cycle pulse when the requested delay has elapsed |

## Verification
The bench uses a tick rate of 8 per millisecond. It sweeps every request from 0 to 110 ms and then adds 120, 150 and 500 ms. For each request it compares the exact edge count to `done` against the closed-form total.

The sweep separates the three segment regimes:
- 0 ms shows the bypass with no segment loaded.
- 1 to 50 ms shows a single segment.
- 51 ms and above shows the 50 ms split, where an off-by-one in the threshold shifts the total by three cycles.

Further runs check the ignored restart, the single-cycle width of `done`, and a reset in mid-delay.

// File: rtl/msd_pkg.sv
package msd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_WAIT  = 3'd2,
    ST_CLEAR = 3'd3,
    ST_FIN   = 3'd4
  } msd_state_e;

endpackage

// File: rtl/msd_segment_plan.sv
module msd_segment_plan #(
  parameter int MS_W         = 16,
  parameter int CNT_W        = 24,
  parameter int TICKS_PER_MS = 120000,
  parameter int CHUNK_MS     = 50
) (
  input  logic [MS_W-1:0]  owed_ms,
  output logic [MS_W-1:0]  owed_next,
  output logic [CNT_W-1:0] seg_ticks
);

  localparam logic [MS_W-1:0]  CHUNK_M = MS_W'(CHUNK_MS);
  localparam logic [CNT_W-1:0] TPM_C   = CNT_W'(TICKS_PER_MS);

  logic            last_seg;
  logic [MS_W-1:0] seg_ms;

  always_comb begin
    // Final segment when what is owed fits in one chunk
    last_seg  = (owed_ms <= CHUNK_M);
    seg_ms    = last_seg ? owed_ms : CHUNK_M;
    owed_next = last_seg ? '0 : (owed_ms - CHUNK_M);
    seg_ticks = CNT_W'(seg_ms) * TPM_C;
  end

endmodule

// File: rtl/msd_tick_counter.sv
module msd_tick_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clear_en,
  input  logic             run_en,
  output logic [CNT_W-1:0] cnt,
  output logic             expired
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d;
  logic             exp_d;

  always_comb begin
    cnt_d = cnt;
    exp_d = expired;
    if (clear_en) begin
      cnt_d = '0;
      exp_d = 1'b0;
    end else if (load_en) begin
      cnt_d = load_val;
      exp_d = 1'b0;
    end else if (run_en && (cnt != '0)) begin
      cnt_d = cnt - ONE;
      if (cnt == ONE) exp_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else begin
      cnt     <= cnt_d;
      expired <= exp_d;
    end
  end

endmodule

// File: rtl/msd_ctrl.sv
module msd_ctrl
  import msd_pkg::*;
#(
  parameter int MS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [MS_W-1:0] req_ms,
  input  logic [MS_W-1:0] owed_next,
  input  logic            expired,
  input  logic            cnt_zero,
  output logic [MS_W-1:0] owed_ms,
  output logic            seg_load,
  output logic            seg_clear,
  output logic            seg_run,
  output logic            done
);

  msd_state_e      state_q, state_d;
  logic [MS_W-1:0] owed_d;

  always_comb begin
    state_d = state_q;
    owed_d  = owed_ms;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          owed_d  = req_ms;
          state_d = (req_ms == '0) ? ST_FIN : ST_LOAD;
        end
      end
      ST_LOAD: begin
        owed_d  = owed_next;
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (expired && cnt_zero) state_d = ST_CLEAR;
      end
      ST_CLEAR: begin
        state_d = (owed_ms == '0) ? ST_FIN : ST_LOAD;
      end
      ST_FIN: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      owed_ms <= '0;
    end else begin
      state_q <= state_d;
      owed_ms <= owed_d;
    end
  end

  assign seg_load  = (state_q == ST_LOAD);
  assign seg_clear = (state_q == ST_CLEAR);
  assign seg_run   = (state_q == ST_WAIT);
  assign done      = (state_q == ST_FIN);

endmodule

// File: rtl/ms_delay_chunker.sv
module ms_delay_chunker #(
  parameter int MS_W         = 16,
  parameter int CNT_W        = 24,
  parameter int TICKS_PER_MS = 120000,
  parameter int CHUNK_MS     = 50
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [MS_W-1:0] delay_ms,
  output logic            done
);

  localparam int CHUNK_TICKS = CHUNK_MS * TICKS_PER_MS;

  // Reset: asserted asynchronously, released through two flops
  logic rst_meta_n, rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  logic [MS_W-1:0]  rem_ms, rem_next;
  logic [CNT_W-1:0] seg_ticks, tick_cnt;
  logic             seg_load, seg_clear, seg_run, tick_expired;

  msd_segment_plan #(
    .MS_W(MS_W), .CNT_W(CNT_W),
    .TICKS_PER_MS(TICKS_PER_MS), .CHUNK_MS(CHUNK_MS)
  ) u_plan (
    .owed_ms  (rem_ms),
    .owed_next(rem_next),
    .seg_ticks(seg_ticks)
  );

  msd_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .load_en (seg_load),
    .load_val(seg_ticks),
    .clear_en(seg_clear),
    .run_en  (seg_run),
    .cnt     (tick_cnt),
    .expired (tick_expired)
  );

  msd_ctrl #(.MS_W(MS_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .start    (start),
    .req_ms   (delay_ms),
    .owed_next(rem_next),
    .expired  (tick_expired),
    .cnt_zero (tick_cnt == '0),
    .owed_ms  (rem_ms),
    .seg_load (seg_load),
    .seg_clear(seg_clear),
    .seg_run  (seg_run),
    .done     (done)
  );

endmodule

// File: rtl/msd_checker.sv
module msd_checker #(
  parameter int MS_W        = 16,
  parameter int CNT_W       = 24,
  parameter int CHUNK_TICKS = 6000000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic             load,
  input logic [CNT_W-1:0] load_val,
  input logic             clear,
  input logic [CNT_W-1:0] cnt,
  input logic             expired,
  input logic [MS_W-1:0]  rem
);

  // R3
  chunk_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val <= CNT_W'(CHUNK_TICKS)) && (load_val != '0));

  // R2
  rem_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (rem < $past(rem)));

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0) && !expired);

  // R4
  expire_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expired |-> (cnt == '0));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rem == '0) && !load);

endmodule

bind ms_delay_chunker msd_checker #(
  .MS_W(MS_W), .CNT_W(CNT_W), .CHUNK_TICKS(CHUNK_TICKS)
) i_msd_checker (
  .clk     (clk),
  .rst_n   (rst_q_n),
  .done    (done),
  .load    (seg_load),
  .load_val(seg_ticks),
  .clear   (seg_clear),
  .cnt     (tick_cnt),
  .expired (tick_expired),
  .rem     (rem_ms)
);

// File: tb/test_ms_delay_chunker.sv
module test_ms_delay_chunker;

  localparam int TPM   = 8;
  localparam int CHUNK = 50;
  localparam int WDOG  = 190000;

  logic        clk, rst_n, start, done;
  logic [15:0] delay_ms;
  int          n_checks, n_fail, cyc, done_seen;

  ms_delay_chunker #(.TICKS_PER_MS(TPM), .CHUNK_MS(CHUNK)) i_ms_delay_chunker (
    .clk(clk), .rst_n(rst_n), .start(start), .delay_ms(delay_ms), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) if (done) done_seen++;

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WDOG) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles, expected below %0d", cyc, WDOG);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_cycles(input int ms);
    if (ms == 0) return 1;
    return 1 + ms * TPM + 3 * ((ms + CHUNK - 1) / CHUNK);
  endfunction

  // Pulse start and count rising edges until done is seen
  task automatic run_delay(input int ms, output int edges);
    @(negedge clk);
    start = 1'b1; delay_ms = 16'(ms);
    @(posedge clk);
    edges = 1;
    @(negedge clk);
    start = 1'b0;
    while (!done && edges < 20000) begin
      @(posedge clk); edges++; @(negedge clk);
    end
  endtask

  task automatic timed(input string tag, input int ms);
    int e, d0;
    d0 = done_seen;
    run_delay(ms, e);
    check(tag, e, exp_cycles(ms));
    @(negedge clk);
    check("R7 done width", int'(done), 0);
    check("R7 done count", done_seen - d0, 1);
  endtask

  initial begin
    n_checks = 0; n_fail = 0; done_seen = 0;
    start = 1'b0; delay_ms = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check("R9 reset done", int'(done), 0);
    check("R9 idle no done", done_seen, 0);

    timed("R6 zero request", 0);
    for (int ms = 1; ms <= 110; ms++) begin
      if (ms <= CHUNK) timed("R1 R2 R5 single segment", ms);
      else             timed("R1 R3 R4 R5 split", ms);
    end
    timed("R3 R5 120ms", 120);
    timed("R3 R5 150ms", 150);
    timed("R3 R4 R5 500ms", 500);

    // R8: restart attempt and count change mid-delay are ignored
    begin
      int e, d0;
      d0 = done_seen;
      @(negedge clk);
      start = 1'b1; delay_ms = 16'd51;
      @(posedge clk); e = 1;
      @(negedge clk); start = 1'b0; delay_ms = 16'd999;
      repeat (100) begin @(posedge clk); e++; @(negedge clk); end
      start = 1'b1; delay_ms = 16'd3;
      @(posedge clk); e++;
      @(negedge clk); start = 1'b0;
      while (!done && e < 20000) begin @(posedge clk); e++; @(negedge clk); end
      check("R8 ignored start", e, exp_cycles(51));
      repeat (60) @(negedge clk);
      check("R8 single done", done_seen - d0, 1);
    end

    // R9: reset in mid-delay abandons it
    begin
      int d0;
      d0 = done_seen;
      @(negedge clk);
      start = 1'b1; delay_ms = 16'd20;
      @(negedge clk); start = 1'b0;
      repeat (30) @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (300) @(negedge clk);
      check("R9 abandoned delay", done_seen - d0, 0);
      timed("R9 R5 after reset", 7);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule